// File: doc/BRIEF.md
# T1 Receive Alarm Interrupt Word

This block gathers receive-side alarm and framing events from a T1 line interface into one 8-bit sticky interrupt word. Four sources are levels: terminal frame sync, multiframe sync, the all-ones (AIS) condition, and loss of signal. Each level source sets its bit whenever the level changes, in either direction. Two sources are single-cycle pulses, one for a controlled slip in the transmit elastic buffer and one for the receive elastic buffer. Two conditions are worked out inside the block. Digital loss of signal comes from a run of received zero bits. A severely errored framing event comes from a short history of framing-bit results.

A host sets an enable mask through a write strobe and reads the word with a read strobe. A read returns the word and clears it, in one cycle. The interrupt request stays high while any latched bit is set. Framing recovery, the elastic buffers and the analog loss threshold are outside the block and arrive as inputs.

Top module: `t1_alarm_irq`

## Requirements
- R1: After synchronous reset the interrupt word, the enable mask, `rd_data` and `irq` are all zero. With the mask at zero, no source can latch.
- R2: Bit 7 (`term_sync`), bit 6 (`mfrm_sync`) and bit 4 (`ais_det`) latch at the first clock edge at which the input differs from its value at the previous edge. A rise and a fall both count. During reset the previous value is tracked, so releasing reset alone latches nothing.
- R3: Digital loss of signal asserts on the 192nd consecutive received zero. Only cycles with `rx_bit_vld` high count. Cycles with `rx_bit_vld` low neither count nor break the run. Digital loss clears on the first valid received one.
- R4: The loss condition is digital loss OR `analog_los`. Bit 3 latches on every change of that condition, including the change caused by clearing on a one. A change of digital loss latches one cycle after the bit that caused it.
- R5: Bit 2 latches when a framing bit with `frm_bit_err` high arrives while `term_sync` is high and at least one of the previous five framing bits was also in error. The framing history is emptied in every cycle in which `term_sync` is low.
- R6: Bit 1 latches on a `tx_slip` pulse. Bit 0 latches on an `rx_slip` pulse.
- R7: Bit i of `mask_wdata`, written when `mask_wr` is high, enables bit i of the word when it is 1. An event on a masked bit is dropped. It does not appear later when the bit is unmasked.
- R8: When `rd_en` is high, `rd_data` shows the word on the next cycle and the word is cleared. Outside that cycle `rd_data` is zero. Latched bits stay set until a read. Bit 5 is unused and always reads 0.
- R9: An enabled event in the same cycle as a read stays set after the read and is returned by the next read.
- R10: `irq` is active high and equals the OR of all latched bits, updated in the same cycle as the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit_vld | input | 1 | A received line bit is present this cycle |
| rx_bit | input | 1 | Received line bit value |
| analog_los | input | 1 | External analog loss-of-signal level |
| frm_bit_vld | input | 1 | A framing-bit result is present this cycle |
| frm_bit_err | input | 1 | The framing bit was in error |
| term_sync | input | 1 | Terminal frame sync level |
| mfrm_sync | input | 1 | Multiframe sync level |
| ais_det | input | 1 | Received all-ones level |
| tx_slip | input | 1 | Transmit controlled slip pulse |
| rx_slip | input | 1 | Receive controlled slip pulse |
| mask_wr | input | 1 | Write strobe for the enable mask |
| mask_wdata | input | 8 | New enable mask |
| rd_en | input | 1 | Read-and-clear strobe |
| rd_data | output | 8 | Word value returned by a read |
| irq | output | 1 | Interrupt request |

## Verification
A wrong zero-run count or framing history never shows at a port on its own. It only appears as a bit 3 or bit 2 that latches one cycle early, late or never. The bench therefore sets up run lengths of exactly 191 and 192 zeros, error pairs spaced five and six framing bits apart, and a sync drop between two errors. It then reads the word a couple of cycles later. Faults in the mask, clear or collision paths show within one cycle on `irq` and on the next read. A reference model is compared against `irq` and `rd_data` every cycle under random traffic.

// File: rtl/t1_alarm_pkg.sv
package t1_alarm_pkg;
  localparam int WORD_W   = 8;
  localparam int B_TSYNC  = 7;
  localparam int B_MFSYNC = 6;
  localparam int B_AIS    = 4;
  localparam int B_LOS    = 3;
  localparam int B_SEF    = 2;
  localparam int B_TXSLIP = 1;
  localparam int B_RXSLIP = 0;
  localparam logic [WORD_W-1:0] USED_BITS = 8'hDF;
endpackage

// File: rtl/t1_los_run.sv
module t1_los_run #(
  parameter int RUN_LEN = 192
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic bit_val,
  output logic los_dig
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(RUN_LEN);
  localparam logic [CW-1:0] CNT_LAST = CW'(RUN_LEN - 1);

  logic [CW-1:0] zcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      zcnt    <= '0;
      los_dig <= 1'b0;
    end else if (bit_vld) begin
      if (bit_val) begin
        zcnt    <= '0;
        los_dig <= 1'b0;
      end else if (zcnt != CNT_MAX) begin
        zcnt <= zcnt + 1'b1;
        if (zcnt == CNT_LAST) los_dig <= 1'b1;
      end
    end
  end

  AST_LOS_CLEAR_ON_ONE: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && bit_val) |=> !los_dig); // R3
  AST_LOS_RISE_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(los_dig) |-> $past(bit_vld && !bit_val)); // R3
endmodule

// File: rtl/t1_sef_window.sv
module t1_sef_window #(
  parameter int WIN  = 6,
  parameter int ERRS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_ok,
  input  logic fb_vld,
  input  logic fb_err,
  output logic sef_evt
);
  localparam int HW = WIN - 1;

  logic [HW-1:0] hist;

  always_ff @(posedge clk) begin
    if (rst || !sync_ok) hist <= '0;
    else if (fb_vld)     hist <= {hist[HW-2:0], fb_err};
  end

  always_comb
    sef_evt = sync_ok && fb_vld && fb_err && ($countones(hist) >= ERRS - 1);

  AST_HIST_EMPTY_NO_SYNC: assert property (@(posedge clk) disable iff (rst)
    !sync_ok |=> (hist == '0)); // R5
endmodule

// File: rtl/t1_chg_detect.sv
module t1_chg_detect #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] chg
);
  logic [N-1:0] prev;

  always_ff @(posedge clk) prev <= lvl;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign chg[i] = lvl[i] ^ prev[i];
  end
endmodule

// File: rtl/t1_irq_word.sv
module t1_irq_word #(
  parameter int W = 8,
  parameter logic [W-1:0] USED = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ev,
  input  logic         mask_wr,
  input  logic [W-1:0] mask_wdata,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         irq
);
  logic [W-1:0] mask_q, stat_q, stat_nxt, ev_m;

  always_comb begin
    ev_m     = ev & mask_q & USED;
    stat_nxt = (rd_en ? '0 : stat_q) | ev_m;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      stat_q  <= '0;
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= mask_wdata & USED;
      stat_q  <= stat_nxt;
      rd_data <= rd_en ? stat_q : '0;
      irq     <= |stat_nxt;
    end
  end

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(mask_q)) == '0)); // R7
  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (rd_data == $past(stat_q))); // R8
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> ((stat_q & ~$past(ev_m)) == '0)); // R8
  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R8
  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (rst)
    (ev_m != '0) |=> ((stat_q & $past(ev_m)) == $past(ev_m))); // R9
  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (rst)
    irq == (stat_q != '0)); // R10
endmodule

// File: rtl/t1_alarm_irq.sv
module t1_alarm_irq
  import t1_alarm_pkg::*;
#(
  parameter int LOS_ZEROS = 192,
  parameter int SEF_WIN   = 6,
  parameter int SEF_ERRS  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_bit_vld,
  input  logic              rx_bit,
  input  logic              analog_los,
  input  logic              frm_bit_vld,
  input  logic              frm_bit_err,
  input  logic              term_sync,
  input  logic              mfrm_sync,
  input  logic              ais_det,
  input  logic              tx_slip,
  input  logic              rx_slip,
  input  logic              mask_wr,
  input  logic [WORD_W-1:0] mask_wdata,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              irq
);
  localparam int NLVL = 4;

  logic              los_dig, los_cond, sef_evt;
  logic [NLVL-1:0]   lvl, chg;
  logic [WORD_W-1:0] ev;

  t1_los_run #(.RUN_LEN(LOS_ZEROS)) u_los (
    .clk(clk), .rst(rst), .bit_vld(rx_bit_vld), .bit_val(rx_bit), .los_dig(los_dig)
  );

  t1_sef_window #(.WIN(SEF_WIN), .ERRS(SEF_ERRS)) u_sef (
    .clk(clk), .rst(rst), .sync_ok(term_sync), .fb_vld(frm_bit_vld),
    .fb_err(frm_bit_err), .sef_evt(sef_evt)
  );

  assign los_cond = los_dig | analog_los;
  assign lvl      = {term_sync, mfrm_sync, ais_det, los_cond};

  t1_chg_detect #(.N(NLVL)) u_chg (.clk(clk), .lvl(lvl), .chg(chg));

  always_comb begin
    ev           = '0;
    ev[B_TSYNC]  = chg[3];
    ev[B_MFSYNC] = chg[2];
    ev[B_AIS]    = chg[1];
    ev[B_LOS]    = chg[0];
    ev[B_SEF]    = sef_evt;
    ev[B_TXSLIP] = tx_slip;
    ev[B_RXSLIP] = rx_slip;
  end

  t1_irq_word #(.W(WORD_W), .USED(USED_BITS)) u_word (
    .clk(clk), .rst(rst), .ev(ev), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
  );

  AST_UNUSED_BIT_LOW: assert property (@(posedge clk) disable iff (rst)
    rd_data[5] == 1'b0); // R8
endmodule

// File: tb/t1_alarm_irq_bench.sv
module t1_alarm_irq_bench;
  logic clk = 0, rst = 1;
  logic rx_bit_vld = 0, rx_bit = 0, analog_los = 0, frm_bit_vld = 0, frm_bit_err = 0;
  logic term_sync = 0, mfrm_sync = 0, ais_det = 0, tx_slip = 0, rx_slip = 0;
  logic mask_wr = 0, rd_en = 0;
  logic [7:0] mask_wdata = 0;
  logic [7:0] rd_data;
  logic irq;
  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  t1_alarm_irq u_t1_alarm_irq (.*);

  // reference model, driven from the requirements
  int m_zeros; bit m_los; bit m_los_prev, m_ts_prev, m_mf_prev, m_ais_prev;
  bit [4:0] m_hist; bit [7:0] m_stat, m_mask, m_rd; bit m_irq;

  function automatic int ones5(bit [4:0] v);
    int n = 0;
    for (int i = 0; i < 5; i++) n += v[i];
    return n;
  endfunction

  always @(posedge clk) begin
    bit lc; bit [7:0] ev;
    lc = m_los | analog_los;
    if (rst) begin
      m_zeros = 0; m_los = 0; m_hist = 0; m_stat = 0; m_mask = 0; m_rd = 0; m_irq = 0;
    end else begin
      ev = 0;
      ev[7] = term_sync != m_ts_prev;
      ev[6] = mfrm_sync != m_mf_prev;
      ev[4] = ais_det != m_ais_prev;
      ev[3] = lc != m_los_prev;
      ev[2] = term_sync && frm_bit_vld && frm_bit_err && ones5(m_hist) >= 1;
      ev[1] = tx_slip; ev[0] = rx_slip;
      m_rd = rd_en ? m_stat : 8'h00;
      m_stat = ((rd_en ? 8'h00 : m_stat) | (ev & m_mask)) & 8'hDF;
      m_irq = m_stat != 0;
      if (mask_wr) m_mask = mask_wdata & 8'hDF;
      if (!term_sync) m_hist = 0;
      else if (frm_bit_vld) m_hist = {m_hist[3:0], frm_bit_err};
      if (rx_bit_vld) begin
        if (rx_bit) begin m_zeros = 0; m_los = 0; end
        else if (m_zeros < 192) begin m_zeros++; if (m_zeros == 192) m_los = 1; end
      end
    end
    m_los_prev = lc; m_ts_prev = term_sync; m_mf_prev = mfrm_sync; m_ais_prev = ais_det;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // continuous comparison with the model
  always @(negedge clk) if (!rst && !done) begin
    check("R10 irq", {7'b0, irq}, {7'b0, m_irq});
    check("R8 rd_data", rd_data, m_rd);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1; fails++; checks++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic rd_expect(input logic [7:0] exp, input string req);
    rd_en = 1; @(negedge clk); rd_en = 0;
    check(req, rd_data, exp);
  endtask
  task automatic wr_mask(input logic [7:0] m);
    mask_wr = 1; mask_wdata = m; @(negedge clk); mask_wr = 0;
  endtask
  task automatic zeros(input int n);
    for (int i = 0; i < n; i++) begin
      rx_bit_vld = 1; rx_bit = 0; @(negedge clk);
      if (i == 100) begin rx_bit_vld = 0; idle(3); end
    end
    rx_bit_vld = 0;
  endtask
  task automatic fbit(input logic e);
    frm_bit_vld = 1; frm_bit_err = e; @(negedge clk); frm_bit_vld = 0; frm_bit_err = 0;
  endtask

  initial begin
    void'($urandom(1234));
    idle(5); rst = 0; idle(1);
    check("R1 irq", {7'b0, irq}, 8'h00);
    rd_expect(8'h00, "R1");
    // masked events are dropped
    term_sync = 1; idle(2);
    tx_slip = 1; @(negedge clk); tx_slip = 0;
    rd_expect(8'h00, "R7 masked");
    wr_mask(8'hFF);
    rd_expect(8'h00, "R7 no late latch");
    // level changes both ways
    term_sync = 0; idle(1);
    check("R10 irq set", {7'b0, irq}, 8'h01);
    rd_expect(8'h80, "R2 fall");
    check("R8 irq after clear", {7'b0, irq}, 8'h00);
    term_sync = 1; idle(1); rd_expect(8'h80, "R2 rise");
    mfrm_sync = 1; ais_det = 1; idle(1); rd_expect(8'h50, "R2 mf+ais");
    mfrm_sync = 0; idle(1); rd_expect(8'h40, "R2 mf fall");
    ais_det = 0; idle(1); rd_expect(8'h10, "R2 ais fall");
    // slips
    tx_slip = 1; @(negedge clk); tx_slip = 0; rd_expect(8'h02, "R6 tx");
    rx_slip = 1; @(negedge clk); rx_slip = 0; rd_expect(8'h01, "R6 rx");
    // event colliding with read
    rd_en = 1; tx_slip = 1; @(negedge clk); rd_en = 0; tx_slip = 0;
    check("R9 read value", rd_data, 8'h00);
    check("R9 irq", {7'b0, irq}, 8'h01);
    rd_expect(8'h02, "R9 kept");
    // loss of signal
    rx_bit_vld = 1; rx_bit = 1; @(negedge clk); rx_bit_vld = 0;
    zeros(191); idle(2); rd_expect(8'h00, "R3 191 zeros");
    zeros(1); idle(2); rd_expect(8'h08, "R3 192 zeros");
    zeros(20); idle(2); rd_expect(8'h00, "R3 stays");
    rx_bit_vld = 1; rx_bit = 1; @(negedge clk); rx_bit_vld = 0; rx_bit = 0;
    idle(2); rd_expect(8'h08, "R4 clear on one");
    analog_los = 1; idle(2); rd_expect(8'h08, "R4 analog rise");
    analog_los = 0; idle(2); rd_expect(8'h08, "R4 analog fall");
    // severely errored framing
    repeat (6) fbit(0);
    fbit(1); repeat (4) fbit(0); fbit(1); rd_expect(8'h04, "R5 gap five");
    repeat (6) fbit(0);
    fbit(1); repeat (5) fbit(0); fbit(1); rd_expect(8'h00, "R5 gap six");
    repeat (6) fbit(0);
    fbit(1); term_sync = 0; idle(1); term_sync = 1; idle(1); fbit(1);
    rd_expect(8'h80, "R5 history cleared");
    fbit(1); rd_expect(8'h04, "R5 back to back");
    // random traffic against the model
    for (int c = 0; c < 6000; c++) begin
      rx_bit_vld  = ($urandom % 2) == 0;
      rx_bit      = ($urandom % 300) == 0;
      frm_bit_vld = ($urandom % 4) == 0;
      frm_bit_err = ($urandom % 4) == 0;
      if ($urandom % 64 == 0)  term_sync  = ~term_sync;
      if ($urandom % 64 == 0)  mfrm_sync  = ~mfrm_sync;
      if ($urandom % 64 == 0)  ais_det    = ~ais_det;
      if ($urandom % 400 == 0) analog_los = ~analog_los;
      tx_slip = ($urandom % 150) == 0;
      rx_slip = ($urandom % 150) == 0;
      rd_en   = ($urandom % 8) == 0;
      mask_wr = ($urandom % 200) == 0;
      mask_wdata = 8'($urandom);
      @(negedge clk);
    end
    {rx_bit_vld, frm_bit_vld, tx_slip, rx_slip, mask_wr, rd_en} = '0;
    idle(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule